// File: doc/BRIEF.md
# Multi-channel pin glitch filter

This block holds a bank of digital glitch filters for one port of input pins. Every pin has its own filter and its own enable bit. The whole bank shares one width setting and one choice of filter clock. That clock is either the fast system clock or a slow low-power strobe, which arrives as a one-cycle tick in the system clock domain.

An enabled filter passes its raw pin through a two-flop synchronizer that advances only on the active filter-clock enable. It then compares the synchronized value with its own output. A counter measures how many consecutive filter-clock edges the two have disagreed, and the output only takes the synchronized value once that run reaches the programmed width. Any edge on which the two agree clears the counter. As a result, a pulse that is too short never reaches the output.

A stop-mode input freezes filters that run on the fast clock. Filters on the slow strobe keep running during stop mode. Width and source may only be changed while every filter is disabled. All ports are plain level signals.

Top module: `pin_glitch_bank`

## Requirements
- R1: While rst_n is low, every bit of pin_out is 0.
- R2: On the clock edge after a channel's enable bit is sampled 0, that channel's output is 0. This holds whatever the pin, the stop-mode input or the filter clock is doing.
- R3: With the fast clock selected, stop_mode low and filt_len = 0, a pin level driven before clock edge E0 appears on pin_out after edge E2. It is still absent after edge E1.
- R4: With filt_len = N, the output takes the synchronized value on the (N+1)-th consecutive filter-clock edge at which the two differ. A pulse lasting N or fewer filter-clock cycles is rejected, and one lasting N+1 cycles gets through. The pin-to-output latency is N+3 filter-clock edges.
- R5: Channels are filtered independently. A mismatch run on one channel neither advances nor clears the count of another channel.
- R6: With use_slow = 1, the filters advance only in cycles where slow_tick = 1. Outputs never change on other cycles except through R2. stop_mode has no effect in this mode.
- R7: With use_slow = 0 and stop_mode = 1, no enabled filter's synchronizer, counter or output advances. After stop_mode is released, a pending pin level takes the full R3/R4 latency.
- R8: A single filter-clock edge on which the synchronized input equals the output restarts the mismatch count. Two pulses of N cycles with a one-cycle gap are both rejected.
- R9: A channel that is re-enabled starts from cleared synchronizers. Its output rises no sooner than edge E2 after the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw pin levels |
| chan_en | input | NUM_PINS | Per-channel filter enable |
| filt_len | input | LEN_W | Shared width in filter-clock cycles |
| use_slow | input | 1 | 0 selects the fast clock, 1 selects the slow tick |
| stop_mode | input | 1 | Freezes fast-clock filters |
| slow_tick | input | 1 | One-cycle strobe of the slow clock |
| pin_out | output | NUM_PINS | Filtered levels |

## Verification
Two kinds of event can land on the same edge. The first pair is a channel being disabled and the bank being frozen by stop mode. The bench drops half the enables while stop_mode is high and the outputs are high. It expects those channels to clear on the very next edge while the others hold. The second pair is a slow tick and stop mode. The bench keeps stop_mode high across a whole slow-mode sequence and expects the ticks to advance the filters anyway, with the outputs rising exactly on the fourth tick for a width of one.

// File: rtl/gf_pkg.sv
package gf_pkg;
  typedef enum logic {SRC_FAST = 1'b0, SRC_SLOW = 1'b1} gf_src_e;
  localparam int unsigned GF_SYNC_STAGES = 2;
endpackage

// File: rtl/gf_adv_gen.sv
module gf_adv_gen
  import gf_pkg::*;
(
  input  logic use_slow,
  input  logic stop_mode,
  input  logic slow_tick,
  output logic adv
);
  gf_src_e src;

  always_comb begin
    src = gf_src_e'(use_slow);
    unique case (src)
      SRC_SLOW: adv = slow_tick;
      default:  adv = !stop_mode;
    endcase
  end
endmodule

// File: rtl/gf_chan.sv
module gf_chan #(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             en,
  input  logic             pin,
  input  logic [LEN_W-1:0] len,
  output logic             out
);
  import gf_pkg::*;

  logic [GF_SYNC_STAGES-1:0] sync_q;
  logic [LEN_W-1:0]          run_q;
  logic                      out_q;
  logic                      synced;
  logic                      differ;
  logic                      expire;

  assign synced = sync_q[GF_SYNC_STAGES-1];
  assign differ = synced != out_q;
  assign expire = run_q >= len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      out_q  <= 1'b0;
    end else if (!en) begin
      sync_q <= '0;
      run_q  <= '0;
      out_q  <= 1'b0;
    end else if (adv) begin
      sync_q <= {sync_q[GF_SYNC_STAGES-2:0], pin};
      if (!differ) begin
        run_q <= '0;
      end else if (expire) begin
        out_q <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign out = out_q;
endmodule

// File: rtl/pin_glitch_bank.sv
module pin_glitch_bank #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] chan_en,
  input  logic [LEN_W-1:0]    filt_len,
  input  logic                use_slow,
  input  logic                stop_mode,
  input  logic                slow_tick,
  output logic [NUM_PINS-1:0] pin_out
);
  logic adv;

  gf_adv_gen i_adv (
    .use_slow (use_slow),
    .stop_mode(stop_mode),
    .slow_tick(slow_tick),
    .adv      (adv)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chan
    gf_chan #(.LEN_W(LEN_W)) i_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (adv),
      .en   (chan_en[g]),
      .pin  (pin_in[g]),
      .len  (filt_len),
      .out  (pin_out[g])
    );
  end
endmodule

// File: rtl/pin_glitch_bank_chk.sv
module pin_glitch_bank_chk #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] chan_en,
  input logic                use_slow,
  input logic                stop_mode,
  input logic                slow_tick,
  input logic [NUM_PINS-1:0] pin_out
);
  // R2: a channel whose enable was low on the previous edge shows 0
  p_disabled_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~$past(chan_en)) == '0);

  // R7: fast clock plus stop holds outputs, apart from disable clearing
  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_slow && stop_mode) |=> pin_out == ($past(pin_out) & $past(chan_en)));

  // R6: in slow mode nothing moves without a tick
  p_slow_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_slow && !slow_tick) |=> pin_out == ($past(pin_out) & $past(chan_en)));

  // R3: in free-running fast mode a rising output traces back to a high pin three edges earlier
  p_rise_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!use_slow && !stop_mode, 1) && $past(!use_slow && !stop_mode, 2) &&
     $past(!use_slow && !stop_mode, 3))
    |-> ((pin_out & ~$past(pin_out) & ~$past(pin_in, 3)) == '0));
endmodule

bind pin_glitch_bank pin_glitch_bank_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_in   (pin_in),
  .chan_en  (chan_en),
  .use_slow (use_slow),
  .stop_mode(stop_mode),
  .slow_tick(slow_tick),
  .pin_out  (pin_out)
);

// File: tb/test_pin_glitch_bank.sv
module test_pin_glitch_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] chan_en = '0;
  logic [LW-1:0] filt_len = '0;
  logic          use_slow = 1'b0;
  logic          stop_mode = 1'b0;
  logic          slow_tick = 1'b0;
  logic [NP-1:0] pin_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_glitch_bank #(.NUM_PINS(NP), .LEN_W(LW)) i_pin_glitch_bank (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chan_en(chan_en),
    .filt_len(filt_len), .use_slow(use_slow), .stop_mode(stop_mode),
    .slow_tick(slow_tick), .pin_out(pin_out)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input logic [NP-1:0] exp, input string req);
    n_checks++;
    if (pin_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out=%h expected %h at %0t", req, pin_out, exp, $time);
    end
  endtask

  task automatic t_reset();
    step(3);
    check('0, "R1 reset");
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_pass_w0();
    chan_en = '1; filt_len = '0;
    pin_in = 16'hA5A5;
    step(2);
    check('0, "R3 not yet after E1");
    step(1);
    check(16'hA5A5, "R3 visible after E2");
  endtask

  task automatic t_width();
    filt_len = 5'd4;
    pin_in = '0;
    step(6);
    check(16'hA5A5, "R4 held before N+3");
    step(1);
    check('0, "R4 update at N+3");
  endtask

  task automatic t_reject();
    filt_len = 5'd3;
    pin_in = 16'h0001; step(3); pin_in = '0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      check('0, "R4 short pulse rejected");
    end
    pin_in = 16'h0001; step(4); pin_in = '0;
    step(2);
    check(16'h0001, "R4 N+1 pulse passes");
    step(12);
    check('0, "R4 returns low");
  endtask

  task automatic t_restart();
    pin_in = 16'h0001; step(3);
    pin_in = '0;       step(1);
    pin_in = 16'h0001; step(3);
    pin_in = '0;
    for (int i = 0; i < 10; i++) begin
      check('0, "R8 gap restarts count");
      step(1);
    end
  endtask

  task automatic t_indep();
    pin_in = 16'h0001; step(2);
    pin_in = 16'h0003; step(4);
    check(16'h0001, "R5 channel 0 alone");
    step(2);
    check(16'h0003, "R5 channel 1 own timing");
    pin_in = '0;
    step(12);
    check('0, "R5 settle low");
  endtask

  task automatic t_stop();
    filt_len = '0;
    pin_in = '1; stop_mode = 1'b1;
    step(10);
    check('0, "R7 frozen in stop");
    stop_mode = 1'b0;
    step(2);
    check('0, "R7 full latency after stop");
    step(1);
    check('1, "R7 update after release");
  endtask

  task automatic t_disable();
    stop_mode = 1'b1;
    chan_en = 16'h0F0F;
    step(1);
    check(16'h0F0F, "R2 disable during stop");
    stop_mode = 1'b0;
    step(3);
    check(16'h0F0F, "R2 stays low while disabled");
    chan_en = '1;
    step(2);
    check(16'h0F0F, "R9 restart from clear sync");
    step(1);
    check('1, "R9 rises at E2");
  endtask

  task automatic slow_pulse();
    slow_tick = 1'b1; step(1);
    slow_tick = 1'b0; step(2);
  endtask

  task automatic t_slow();
    chan_en = '0;
    step(1);
    check('0, "R2 all disabled");
    use_slow = 1'b1; filt_len = 5'd1; stop_mode = 1'b1;
    pin_in = 16'h00FF; chan_en = '1;
    step(20);
    check('0, "R6 no tick no advance");
    slow_pulse(); slow_pulse(); slow_pulse();
    check('0, "R6 three ticks not enough");
    slow_pulse();
    check(16'h00FF, "R6 fourth tick updates under stop");
  endtask

  initial begin
    t_reset();
    t_pass_w0();
    t_width();
    t_reject();
    t_restart();
    t_indep();
    t_stop();
    t_disable();
    t_slow();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule